// File: doc/BRIEF.md
# Periodic Self-Test Supervisor with End-of-Life Alarm

This block supervises a protection device through its whole powered life. Once the supply is reported valid after power-on, it first confirms that a monitored connection reads as intact. It then waits one second and opens a self-test window. Inside that window it fires up to four evenly spaced test-drive strobes. The first pass reported by the sensing logic closes the window as healthy. If the window runs out with no pass, the block latches an end-of-life alarm. A healthy window is followed by a long idle interval, nominally 90 minutes, and then by the next window.

All timing is counted in ticks of a 1 kHz timebase input. While latched, the alarm pin toggles every 133 ticks, which gives roughly a 3.75 Hz square wave. The block remembers why the alarm latched. A press of the manual-test button clears an alarm caused by a failed self-test and schedules a retest one second later. A press cannot clear an alarm caused by a failed continuity check; only a power-on reset clears that one.

The long interval is divided by a parameter, so that a simulation can cover several windows in a short run.

Top module: `selftest_supervisor`

## Requirements
- R1: While `rst` is high, and afterwards for as long as `supply_ok` stays low, both `alarm_out` and `test_strobe` stay low.
- R2: After `supply_ok` rises, `cont_good` is watched on every clock. If `cont_good` has not been seen high by the 60th tick, `alarm_out` rises one clock after that tick. If `cont_good` is seen high before then, no alarm is raised.
- R3: A good continuity result starts a retest delay of 1000 ticks, after which a self-test window opens.
- R4: A window makes at most 4 attempts. An attempt is a one-clock `test_strobe`, issued one clock after window ticks 0, 16, 32 and 48, so consecutive strobes are exactly 16 ticks apart.
- R5: A `test_pass` seen high on any clock inside a window ends that window: no further strobes are issued and no alarm is raised.
- R6: A window with no pass expires on its 66th tick. `alarm_out` rises one clock later, which is 65 ticks plus one clock after the first strobe of that window.
- R7: While the alarm is latched, `alarm_out` starts high and changes level on every 133rd tick. The first high phase is one clock shorter, because it starts one clock after entry.
- R8: After a passing window, the next window opens after PERIOD_TICKS = 5,400,000 / PERIOD_DIV ticks. Its first strobe follows the tick after that.
- R9: A manual press during an alarm that was caused by a self-test failure clears `alarm_out` and starts the 1000-tick retest delay.
- R10: A manual press during an alarm that was caused by a continuity failure is refused. The alarm keeps toggling and no window opens.
- R11: A manual press while no alarm is latched has no effect on the schedule.
- R12: A power-on reset clears a latched alarm on the next clock. The continuity check then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_1k | input | 1 | One-clock timebase pulse, nominally 1 kHz |
| supply_ok | input | 1 | Supply has reached its valid level |
| cont_good | input | 1 | Monitored connection reads as intact |
| test_pass | input | 1 | Sensing logic reports a successful test attempt |
| manual_btn | input | 1 | Raw, asynchronous manual-test button |
| test_strobe | output | 1 | One-clock pulse that starts a test attempt |
| alarm_out | output | 1 | End-of-life alarm, a square wave while latched |

## Verification
The assertions take several things for granted about the inputs:
- `tick_1k` is a single-clock pulse that is separated from the next one by at least one idle clock.
- `test_pass` is raised only in reply to a strobe.
- Power is removed only through `rst`.

The stimulus follows these rules. It produces one tick every four clocks. It raises `test_pass` for a single clock at the moment a strobe is seen. It holds the button for ten clocks so that the two-flop synchroniser sees one clean edge.

// File: rtl/st_sup_pkg.sv
`timescale 1ns/1ps
package st_sup_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_SUPPLY,
    ST_CONT,
    ST_DELAY,
    ST_WINDOW,
    ST_PERIOD,
    ST_ALARM
  } sup_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE,
    CAUSE_SELF,
    CAUSE_CONT
  } alarm_cause_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/st_btn_sync.sv
`timescale 1ns/1ps
module st_btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_i,
  output logic press_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      last_q  <= 1'b0;
      press_o <= 1'b0;
    end else begin
      sync_q  <= {sync_q[STAGES-2:0], btn_i};
      last_q  <= sync_q[STAGES-1];
      press_o <= sync_q[STAGES-1] & ~last_q;
    end
  end

  // R9
  press_single_chk: assert property (@(posedge clk) disable iff (rst)
    press_o |=> !press_o);

endmodule

// File: rtl/st_window_seq.sv
`timescale 1ns/1ps
module st_window_seq #(
  parameter int WIN_TICKS = 66,
  parameter int ATTEMPTS  = 4,
  parameter int GAP_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic run_i,
  output logic strobe_o,
  output logic expire_o
);
  localparam int CW = $clog2(WIN_TICKS + ATTEMPTS * GAP_TICKS + 1);
  localparam int AW = $clog2(ATTEMPTS + 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN_TICKS - 1);
  localparam logic [CW-1:0] GAP      = CW'(GAP_TICKS);
  localparam logic [AW-1:0] ATT_MAX  = AW'(ATTEMPTS);

  logic [CW-1:0] wcnt_q;
  logic [CW-1:0] next_at_q;
  logic [AW-1:0] att_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      wcnt_q    <= '0;
      next_at_q <= '0;
      att_q     <= '0;
      strobe_o  <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      if (tick_i) begin
        wcnt_q <= wcnt_q + 1'b1;
        if (wcnt_q == next_at_q && att_q < ATT_MAX) begin
          strobe_o  <= 1'b1;
          att_q     <= att_q + 1'b1;
          next_at_q <= next_at_q + GAP;
        end
      end
    end
  end

  assign expire_o = run_i && tick_i && (wcnt_q == WIN_LAST);

  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);

  // R4
  attempt_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (att_q == ATT_MAX) |=> !strobe_o);

  // R5
  strobe_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> $past(run_i));

endmodule

// File: rtl/st_blinker.sv
`timescale 1ns/1ps
module st_blinker #(
  parameter int HALF_TICKS = 133
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic en_i,
  output logic out_o
);
  localparam int HW = $clog2(HALF_TICKS + 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_TICKS - 1);

  logic [HW-1:0] cnt_q;
  logic          lvl_q;
  logic          lvl_n;

  always_comb begin
    lvl_n = lvl_q;
    if (!en_i) lvl_n = 1'b1;
    else if (tick_i && cnt_q == HALF_LAST) lvl_n = ~lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
      out_o <= 1'b0;
    end else begin
      lvl_q <= lvl_n;
      out_o <= en_i & lvl_n;
      if (!en_i) cnt_q <= '0;
      else if (tick_i) cnt_q <= (cnt_q == HALF_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // R7
  toggle_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ((out_o != $past(out_o)) && $past(en_i) && $past(en_i, 2)) |-> $past(tick_i));

endmodule

// File: rtl/selftest_supervisor.sv
`timescale 1ns/1ps
module selftest_supervisor
  import st_sup_pkg::*;
#(
  parameter int CONT_TICKS   = 60,
  parameter int RETEST_TICKS = 1000,
  parameter int WIN_TICKS    = 66,
  parameter int ATTEMPTS     = 4,
  parameter int GAP_TICKS    = 16,
  parameter int HALF_TICKS   = 133,
  parameter int PERIOD_DIV   = 1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1k,
  input  logic supply_ok,
  input  logic cont_good,
  input  logic test_pass,
  input  logic manual_btn,
  output logic test_strobe,
  output logic alarm_out
);
  localparam int PERIOD_TICKS = 5_400_000 / PERIOD_DIV;
  localparam int TMAX = imax(imax(CONT_TICKS, RETEST_TICKS), PERIOD_TICKS);
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] CONT_LAST   = TW'(CONT_TICKS - 1);
  localparam logic [TW-1:0] DELAY_LAST  = TW'(RETEST_TICKS - 1);
  localparam logic [TW-1:0] PERIOD_LAST = TW'(PERIOD_TICKS - 1);

  sup_state_e   state_q, state_d;
  alarm_cause_e cause_q;
  logic [TW-1:0] cnt_q;
  logic          press;
  logic          win_expire;
  logic          timed_state;

  st_btn_sync #(.STAGES(SYNC_STAGES)) u_btn (
    .clk(clk), .rst(rst), .btn_i(manual_btn), .press_o(press)
  );

  st_window_seq #(
    .WIN_TICKS(WIN_TICKS), .ATTEMPTS(ATTEMPTS), .GAP_TICKS(GAP_TICKS)
  ) u_win (
    .clk(clk), .rst(rst), .tick_i(tick_1k), .run_i(state_q == ST_WINDOW),
    .strobe_o(test_strobe), .expire_o(win_expire)
  );

  st_blinker #(.HALF_TICKS(HALF_TICKS)) u_blink (
    .clk(clk), .rst(rst), .tick_i(tick_1k), .en_i(state_q == ST_ALARM),
    .out_o(alarm_out)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_SUPPLY: if (supply_ok) state_d = ST_CONT;
      ST_CONT: begin
        if (cont_good) state_d = ST_DELAY;
        else if (tick_1k && cnt_q == CONT_LAST) state_d = ST_ALARM;
      end
      ST_DELAY:  if (tick_1k && cnt_q == DELAY_LAST) state_d = ST_WINDOW;
      ST_WINDOW: begin
        if (test_pass) state_d = ST_PERIOD;
        else if (win_expire) state_d = ST_ALARM;
      end
      ST_PERIOD: if (tick_1k && cnt_q == PERIOD_LAST) state_d = ST_WINDOW;
      ST_ALARM:  if (press && cause_q == CAUSE_SELF) state_d = ST_DELAY;
      default:   state_d = ST_WAIT_SUPPLY;
    endcase
  end

  assign timed_state = (state_q == ST_CONT) || (state_q == ST_DELAY) ||
                       (state_q == ST_PERIOD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT_SUPPLY;
      cnt_q   <= '0;
      cause_q <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else if (tick_1k && timed_state) cnt_q <= cnt_q + 1'b1;
      if (state_d == ST_ALARM && state_q == ST_CONT) cause_q <= CAUSE_CONT;
      else if (state_d == ST_ALARM && state_q == ST_WINDOW) cause_q <= CAUSE_SELF;
    end
  end

  // R6
  alarm_from_state_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_out |-> $past(state_q == ST_ALARM));

  // R10
  cont_alarm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cause_q == CAUSE_CONT) |=> (cause_q == CAUSE_CONT) && (state_q == ST_ALARM));

  // R5
  strobe_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    test_strobe |-> $past(state_q == ST_WINDOW));

  // R3
  window_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WINDOW && $past(state_q) != ST_WINDOW) |->
      ($past(state_q) == ST_DELAY || $past(state_q) == ST_PERIOD));

endmodule

// File: tb/selftest_supervisor_tb.sv
`timescale 1ns/1ps
module selftest_supervisor_tb;
  localparam int TP   = 4;
  localparam int PDIV = 2700;
  localparam int PT   = 5_400_000 / PDIV;
  localparam int RD   = 1000;
  localparam int GAP  = 16;
  localparam int WIN  = 66;
  localparam int HALF = 133;
  localparam int CONT = 60;
  localparam int WD   = 190000;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic supply_ok = 1'b0, cont_good = 1'b0, test_pass = 1'b0, manual_btn = 1'b0;
  logic test_strobe, alarm_out;
  int n_chk = 0, n_bad = 0, cyc = 0, div = 0;

  selftest_supervisor #(.PERIOD_DIV(PDIV)) u_dut (
    .clk(clk), .rst(rst), .tick_1k(tick), .supply_ok(supply_ok),
    .cont_good(cont_good), .test_pass(test_pass), .manual_btn(manual_btn),
    .test_strobe(test_strobe), .alarm_out(alarm_out)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    div  <= (div == TP - 1) ? 0 : div + 1;
    tick <= (div == TP - 1);
    if (cyc == WD) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Waits for a strobe, counting ticks seen while it is low; may press the button.
  task automatic wait_strobe(input int limit, input int press_after,
                             output int ticks, output bit seen, output bit al);
    bit pressed = 0;
    int hold = 0;
    ticks = 0; seen = 0; al = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      test_pass = 1'b0;
      if (pressed) begin
        hold++;
        if (hold == 10) manual_btn = 1'b0;
      end else if (press_after >= 0 && ticks == press_after) begin
        manual_btn = 1'b1;
        pressed = 1;
      end
      if (alarm_out) al = 1;
      if (test_strobe) begin
        seen = 1;
        break;
      end
      if (tick) ticks++;
    end
    manual_btn = 1'b0;
  endtask

  task automatic wait_alarm(input logic level, input int limit,
                            output bit ok, output bit strobe_seen);
    ok = 0; strobe_seen = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      test_pass = 1'b0;
      if (test_strobe) strobe_seen = 1;
      if (alarm_out == level) begin
        ok = 1;
        break;
      end
    end
  endtask

  initial begin
    int tk, t0, tp, cnt;
    bit seen, al, ok, ss, any;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(alarm_out == 0 && test_strobe == 0, "R1 outputs after reset", alarm_out, 0);
    any = 0;
    repeat (400) begin
      @(negedge clk);
      if (alarm_out || test_strobe) any = 1;
    end
    check(!any, "R1 quiet without supply", any, 0);

    // Power-up with continuity good
    cont_good = 1'b1; supply_ok = 1'b1;
    wait_strobe(6000, -1, tk, seen, al);
    check(seen && tk >= RD && tk <= RD + 3, "R3 first window after delay", tk, RD);
    t0 = cyc; tp = cyc;
    for (int k = 2; k <= 3; k++) begin
      wait_strobe(GAP * TP + 10, -1, tk, seen, al);
      check(seen && (cyc - tp) == GAP * TP, "R4 strobe spacing", cyc - tp, GAP * TP);
      tp = cyc;
    end
    test_pass = 1'b1;
    wait_strobe((PT + 20) * TP, -1, tk, seen, al);
    check(!al, "R5 pass leaves alarm low", al, 0);
    check(seen && tk == PT + 1, "R8 period to next window", tk, PT + 1);

    // Window with no pass
    t0 = cyc; tp = cyc;
    for (int k = 2; k <= 4; k++) begin
      wait_strobe(GAP * TP + 10, -1, tk, seen, al);
      check(seen && (cyc - tp) == GAP * TP, "R4 strobe spacing no pass", cyc - tp, GAP * TP);
      tp = cyc;
    end
    wait_alarm(1'b1, WIN * TP, ok, ss);
    check(ok && !ss, "R4 no fifth strobe", ss, 0);
    check(ok && (cyc - t0) == 65 * TP + 1, "R6 expiry to alarm", cyc - t0, 65 * TP + 1);

    tp = cyc;
    wait_alarm(1'b0, 140 * TP, ok, ss);
    check(ok && (cyc - tp) == HALF * TP - 1, "R7 first high phase", cyc - tp, HALF * TP - 1);
    tp = cyc;
    wait_alarm(1'b1, 140 * TP, ok, ss);
    check(ok && (cyc - tp) == HALF * TP, "R7 low phase", cyc - tp, HALF * TP);
    tp = cyc;
    wait_alarm(1'b0, 140 * TP, ok, ss);
    check(ok && (cyc - tp) == HALF * TP, "R7 high phase", cyc - tp, HALF * TP);

    // Manual clear of a self-test alarm
    wait_strobe((RD + 20) * TP, 0, tk, seen, al);
    check(!al, "R9 alarm cleared by press", al, 0);
    check(seen && tk >= RD && tk <= RD + 3, "R9 retest after delay", tk, RD);
    test_pass = 1'b1;
    wait_strobe((PT + 20) * TP, 200, tk, seen, al);
    check(seen && tk == PT + 1, "R11 press while idle ignored", tk, PT + 1);

    // Fail again, then power-on reset
    wait_alarm(1'b1, (WIN + 5) * TP, ok, ss);
    check(ok, "R6 second expiry raises alarm", ok, 1);
    repeat (200 * TP) @(negedge clk);
    rst = 1'b1; cont_good = 1'b0;
    @(negedge clk);
    check(alarm_out == 0 && test_strobe == 0, "R12 reset clears alarm", alarm_out, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cnt = 0; ok = 0;
    for (int i = 0; i < 80 * TP; i++) begin
      @(negedge clk);
      if (alarm_out) begin
        ok = 1;
        break;
      end
      if (tick) cnt++;
    end
    check(ok && cnt == CONT, "R2 continuity timeout", cnt, CONT);

    // Refused press on continuity alarm
    wait_strobe(300 * TP, 0, tk, seen, al);
    check(!seen, "R10 no window after refused press", seen, 0);
    wait_alarm(1'b0, 140 * TP, ok, ss);
    wait_alarm(1'b1, 140 * TP, seen, ss);
    check(ok && seen, "R10 alarm keeps toggling", ok & seen, 1);

    // Continuity recovers in time
    rst = 1'b1; cont_good = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (30 * TP) @(negedge clk);
    cont_good = 1'b1;
    wait_strobe((RD + 100) * TP, -1, tk, seen, al);
    check(seen && !al, "R2 late good continuity avoids alarm", al, 0);
    check(seen && tk >= RD && tk <= RD + 3, "R3 window after recovered check", tk, RD);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule